// File: doc/BRIEF.md
# Converter Serial Port Slave

This block is the device side of the serial port on a multi-channel delta-sigma converter. A host lowers chip select and clocks the serial clock. The block then presents a 32-bit result word on serial data out, most significant bit first. At the same time it collects a channel byte and then a configuration byte from serial data in. The block counts falling clock edges. When chip select rises, the count decides which of the incoming bytes arrived in full, and only those bytes are committed. The rising edge of chip select also starts a new conversion.

The conversion is modelled as a busy interval of `CONV_CYCLES` system clocks. When the interval ends, the value on a test data input is captured as the next result. All three serial pins pass through a synchronizer, and their edges are detected in the system clock domain. The serial clock idles low. Serial data out changes after a falling clock edge and is sampled by the host before the next rising edge. Serial data in is captured on rising edges.

Top module: `adc_serial_slave`

## Requirements
- R1: After reset, `chan_o` and `cfg_o` are 0, `busy_o` is 0, and `sdo_oe_o` is 0.
- R2: `sdo_oe_o` is 1 only while the synchronized chip select is low. While chip select is high, serial data out is released.
- R3: The word is latched when chip select falls. It is sent MSB first with bit 31 as the first bit, and it advances one bit on each falling serial clock edge. Bit 31 is the end-of-conversion flag. Bit 30 is 0. Bits 29..0 hold the result, and bit 29 is its sign. After 32 falling edges the line reads 0.
- R4: Serial data in is captured on rising serial clock edges, MSB first. The first 8 bits form the channel byte and the next 8 bits form the configuration byte.
- R5: If chip select rises after fewer than 8 falling edges, `chan_o` and `cfg_o` keep their values.
- R6: If chip select rises after 8 to 15 falling edges, `chan_o` takes the new channel byte and `cfg_o` keeps its value.
- R7: If chip select rises after 16 or more falling edges, both `chan_o` and `cfg_o` take the new bytes.
- R8: Every rising edge of chip select starts a conversion. `busy_o` is then 1 for exactly `CONV_CYCLES` clocks. A rising edge during a running conversion restarts the count.
- R9: When a conversion ends, `conv_data_i` is captured as the result. The end-of-conversion flag reads 1 while a conversion runs and 0 once it is done.
- R10: The falling-edge count clears on every rising edge of chip select, so each frame counts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the host, idles low |
| sdi_i | input | 1 | Serial data in |
| conv_data_i | input | 30 | Test value captured as the result when a conversion ends |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for serial data out |
| chan_o | output | 8 | Committed channel select |
| cfg_o | output | 8 | Committed configuration |
| busy_o | output | 1 | Conversion in progress |

## Verification
The assertions assume the host keeps the serial clock low whenever chip select changes. They also assume each level on a serial pin lasts longer than the synchronizer plus one edge-detect register, so that no clock edge coincides with a chip select edge. The properties that relate pin levels to the output enable hold only with the default depth of two synchronizer stages. The stimulus holds every serial clock phase for five system clocks and allows six clocks of settling around each chip select edge. Randomized frames vary only the edge count, the shifted-in bytes and the test data, never this timing.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int WORD_W = 32;
  localparam int DATA_W = 30;
  localparam int CH_W   = 8;
  localparam int CFG_W  = 8;
  localparam int CNT_W  = $clog2(WORD_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CNT_W-1:0]  edge_cnt_t;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift
  import adc_port_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  word_t           word_i,
  input  logic            clr_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            sdi_i,
  output logic            sdo_bit_o,
  output edge_cnt_t       fall_cnt_o,
  output logic [CH_W-1:0] chan_sr_o,
  output logic [CFG_W-1:0] cfg_sr_o
);
  word_t            out_q, out_n;
  edge_cnt_t        cnt_q, cnt_n;
  logic [CH_W-1:0]  chan_q, chan_n;
  logic [CFG_W-1:0] cfg_q, cfg_n;

  always_comb begin
    out_n  = out_q;
    cnt_n  = cnt_q;
    chan_n = chan_q;
    cfg_n  = cfg_q;
    if (load_i)      out_n = word_i;
    else if (fall_i) out_n = {out_q[WORD_W-2:0], 1'b0};
    if (clr_i)                          cnt_n = '0;
    else if (fall_i && cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    if (rise_i) begin
      if (cnt_q < edge_cnt_t'(CH_W))
        chan_n = {chan_q[CH_W-2:0], sdi_i};
      else if (cnt_q < edge_cnt_t'(CH_W + CFG_W))
        cfg_n = {cfg_q[CFG_W-2:0], sdi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      cnt_q  <= '0;
      chan_q <= '0;
      cfg_q  <= '0;
    end else begin
      out_q  <= out_n;
      cnt_q  <= cnt_n;
      chan_q <= chan_n;
      cfg_q  <= cfg_n;
    end
  end

  assign sdo_bit_o  = out_q[WORD_W-1];
  assign fall_cnt_o = cnt_q;
  assign chan_sr_o  = chan_q;
  assign cfg_sr_o   = cfg_q;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_port_pkg::*;
#(
  parameter int CONV_CYCLES = 200
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  data_t data_i,
  output logic  busy_o,
  output data_t result_o
);
  localparam int TW = $clog2(CONV_CYCLES + 1);
  localparam logic [TW-1:0] LOAD_VAL = TW'(CONV_CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;
  data_t         res_q, res_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    res_n  = res_q;
    if (start_i) begin
      cnt_n  = LOAD_VAL;
      busy_n = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_n = 1'b0;
        res_n  = data_i;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      res_q  <= '0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      res_q  <= res_n;
    end
  end

  assign busy_o   = busy_q;
  assign result_o = res_q;
endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
  import adc_port_pkg::*;
#(
  parameter int CONV_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              busy_o
);
  logic [2:0] pins_s;
  logic       cs_s, sck_s, sdi_s;
  logic       cs_d, sck_d;
  logic       cs_rise, cs_fall, sck_rise, sck_fall;
  logic       sdo_bit;
  edge_cnt_t  fall_cnt;
  logic [CH_W-1:0]  chan_sr, chan_q, chan_n;
  logic [CFG_W-1:0] cfg_sr, cfg_q, cfg_n;
  logic       busy;
  data_t      result;
  word_t      out_word;

  adc_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cs_n_i, sck_i, sdi_i}),
    .q_o   (pins_s)
  );
  assign {cs_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_rise  = cs_s & ~cs_d;
  assign cs_fall  = ~cs_s & cs_d;
  assign sck_rise = ~cs_s & sck_s & ~sck_d;
  assign sck_fall = ~cs_s & ~sck_s & sck_d;
  assign out_word = {busy, 1'b0, result};

  adc_frame_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cs_fall),
    .word_i     (out_word),
    .clr_i      (cs_rise),
    .rise_i     (sck_rise),
    .fall_i     (sck_fall),
    .sdi_i      (sdi_s),
    .sdo_bit_o  (sdo_bit),
    .fall_cnt_o (fall_cnt),
    .chan_sr_o  (chan_sr),
    .cfg_sr_o   (cfg_sr)
  );

  always_comb begin
    chan_n = chan_q;
    cfg_n  = cfg_q;
    if (cs_rise && fall_cnt >= edge_cnt_t'(CH_W))          chan_n = chan_sr;
    if (cs_rise && fall_cnt >= edge_cnt_t'(CH_W + CFG_W))  cfg_n  = cfg_sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      cfg_q  <= '0;
    end else begin
      chan_q <= chan_n;
      cfg_q  <= cfg_n;
    end
  end

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (cs_rise),
    .data_i   (conv_data_i),
    .busy_o   (busy),
    .result_o (result)
  );

  assign sdo_oe_o = ~cs_s;
  assign sdo_o    = ~cs_s & sdo_bit;
  assign chan_o   = chan_q;
  assign cfg_o    = cfg_q;
  assign busy_o   = busy;
endmodule

// File: rtl/adc_serial_slave_chk.sv
module adc_serial_slave_chk
  import adc_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_i,
  input logic              sdo_oe_o,
  input logic [CH_W-1:0]   chan_o,
  input logic [CFG_W-1:0]  cfg_o,
  input logic              busy_o,
  input logic [DATA_W-1:0] conv_data_i,
  input logic              cs_rise,
  input edge_cnt_t         fall_cnt,
  input data_t             result
);
  if (SYNC_STAGES == 2) begin : g_oe
    assert_oe_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n_i, 2) |-> !sdo_oe_o);
  end

  assert_chan_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_o) |-> $past(fall_cnt) >= edge_cnt_t'(CH_W));

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(fall_cnt) >= edge_cnt_t'(CH_W + CFG_W));

  assert_busy_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise) |-> busy_o);

  assert_capture_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> result == $past(conv_data_i));

  assert_count_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise) |-> fall_cnt == '0);
endmodule

bind adc_serial_slave adc_serial_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n_i      (cs_n_i),
  .sdo_oe_o    (sdo_oe_o),
  .chan_o      (chan_o),
  .cfg_o       (cfg_o),
  .busy_o      (busy_o),
  .conv_data_i (conv_data_i),
  .cs_rise     (cs_rise),
  .fall_cnt    (fall_cnt),
  .result      (result)
);

// File: tb/adc_serial_slave_tb_top.sv
module adc_serial_slave_tb_top;
  localparam int CONV = 200;
  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, sck, sdi;
  logic [29:0] conv_data;
  logic        sdo, sdo_oe, busy;
  logic [7:0]  chan, cfg;

  int checks = 0;
  int failures = 0;
  logic [7:0]  exp_chan = 8'h00;
  logic [7:0]  exp_cfg  = 8'h00;
  logic [29:0] exp_result = 30'h0;
  int          busy_len;

  always #4 clk = ~clk;

  adc_serial_slave #(.CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .conv_data_i(conv_data), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .chan_o(chan), .cfg_o(cfg), .busy_o(busy)
  );

  function automatic logic [31:0] exp_word(input logic eoc, input logic [29:0] d);
    return {eoc, 1'b0, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // One frame: nfall serial clock pulses, then chip select rises.
  task automatic frame(input int nfall, input logic [15:0] tx, input logic [31:0] word,
                       input logic [29:0] next_data, input bit measure, input bit restart);
    int bad = 0;
    logic [31:0] got = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(sdo_oe == 1'b1, "R2 enable in frame", {31'b0, sdo_oe}, 32'd1);
    for (int i = 0; i < nfall; i++) begin
      logic expb;
      sdi = (i < 16) ? tx[15-i] : 1'b0;
      expb = (i < 32) ? word[31-i] : 1'b0;
      if (i < 32) got[31-i] = sdo;
      if (sdo !== expb) bad++;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    chk(bad == 0, "R3 R9 word bits", got, word);
    conv_data = next_data;
    cs_n = 1'b1;
    busy_len = 0;
    if (measure) begin
      int wait_n = 0;
      while (busy !== 1'b1 && wait_n < 20) begin @(negedge clk); wait_n++; end
      while (busy === 1'b1 && busy_len < 5000) begin @(negedge clk); busy_len++; end
      if (restart)
        chk(busy_len >= CONV, "R8 restart length", busy_len, CONV);
      else
        chk(busy_len == CONV, "R8 busy length", busy_len, CONV);
      exp_result = next_data;
    end else begin
      repeat (6) @(negedge clk);
    end
    chk(sdo_oe == 1'b0, "R2 released", {31'b0, sdo_oe}, 32'd0);
    if (nfall >= 8)  exp_chan = tx[15:8];
    if (nfall >= 16) exp_cfg  = tx[7:0];
    chk(chan == exp_chan, "R4 R5 R6 R7 R10 channel", {24'b0, chan}, {24'b0, exp_chan});
    chk(cfg == exp_cfg, "R4 R5 R6 R7 R10 config", {24'b0, cfg}, {24'b0, exp_cfg});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; conv_data = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(chan == 8'h00 && cfg == 8'h00, "R1 registers", {16'b0, chan, cfg}, 32'd0);
    chk(busy == 1'b0, "R1 busy", {31'b0, busy}, 32'd0);
    chk(sdo_oe == 1'b0, "R1 enable", {31'b0, sdo_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    frame(32, 16'hA53C, exp_word(1'b0, exp_result), 30'h2ABC_1234, 1'b1, 1'b0); // R7
    frame(5,  16'h1234, exp_word(1'b0, exp_result), 30'h1555_0F0F, 1'b1, 1'b0); // R5 R10
    frame(8,  16'h5A77, exp_word(1'b0, exp_result), 30'h3000_0001, 1'b1, 1'b0); // R6 boundary
    frame(15, 16'hC3E1, exp_word(1'b0, exp_result), 30'h0000_0FFF, 1'b1, 1'b0); // R6 upper
    frame(16, 16'h6699, exp_word(1'b0, exp_result), 30'h2000_0000, 1'b1, 1'b0); // R7 boundary
    frame(0,  16'hFFFF, exp_word(1'b0, exp_result), 30'h0123_4567, 1'b1, 1'b0); // R5 zero edges
    frame(40, 16'h0F1E, exp_word(1'b0, exp_result), 30'h3FFF_FFFF, 1'b0, 1'b0); // R3 overrun
    // R9: next frame starts mid-conversion, EOC reads 1 and the old result remains
    frame(16, 16'h8421, exp_word(1'b1, exp_result), 30'h1A2B_3C4D, 1'b1, 1'b1);
    frame(2,  16'h0000, exp_word(1'b0, exp_result), 30'h0000_0000, 1'b1, 1'b0);

    for (int k = 0; k < 30; k++) begin
      int nf = $urandom_range(0, 36);
      logic [15:0] tx = 16'($urandom());
      logic [29:0] nd = 30'($urandom());
      frame(nf, tx, exp_word(1'b0, exp_result), nd, 1'b1, 1'b0);
    end

    summary();
    $finish;
  end
endmodule